// File: doc/BRIEF.md
# Buffered Dual-Alignment PWM Channel

This block generates one pulse-width modulated output from an 8-bit counter that advances only on a clock-enable tick. The counter can either run as a sawtooth (left-aligned pulses that start at the beginning of each period) or as a triangle (center-aligned pulses that sit symmetrically around the turning point). The pulse width comes from an active duty register and the cycle length from an active period register.

Software writes the duty and period values into buffer registers. While the channel runs, the buffers move into the active registers only at the end of a period, so that a period is never produced with a mix of old and new settings. A write of any value to the counter restarts the channel at once: the count goes to zero, counting goes up and both buffers are loaded without waiting. While the channel is disabled the counter is frozen and buffer writes reach the active registers straight away. The current count can be read at any time without side effects.

Top module: `pwm_chan8`

## Requirements
- R1: After reset the count is 0, all buffers and active registers are 0, and the output sits at its inactive level (low when `pol` is 1).
- R2: The counter changes only on a cycle with `tick` high while `chan_en` is high; with `chan_en` low it holds its value, and after re-enabling it continues from the held value. Reading `cnt_rd` never changes the count.
- R3: With `center` = 0 and period P > 0, the count steps 0, 1, ..., P-1 and then returns to 0 on the next tick.
- R4: With `center` = 1 and period P > 0, the count steps up from 0 to P and back down to 0, then repeats; with P = 1 it alternates 0, 1.
- R5: `wr_sel` selects the target of a write: 0 the duty buffer, 1 the period buffer, 2 or 3 the counter. A counter write (any data) sets the count to 0 and the direction to up on the next edge, takes priority over a tick, and loads both active registers from the buffers on that same edge.
- R6: While enabled, the active duty and period registers change only at the end of a period (the return to 0 on a tick) or on a counter write; a buffer written at that same edge is loaded with its new value.
- R7: While `chan_en` is low, a write to the duty or period buffer appears in the active register on the same edge.
- R8: The channel is active when the count is below the active duty value; with `pol` = 1 the active level is high, with `pol` = 0 the output is inverted. In center mode this gives a transition at the duty match on the way up and on the way down.
- R9: An active period of 0 holds the output at the inactive level and the count at 0; an active duty greater than or equal to a nonzero period holds the output at the active level for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | 1 | Channel enable; low freezes the counter |
| tick | input | 1 | Clock-enable strobe from the selected clock source |
| pol | input | 1 | Polarity: 1 means the active level is high |
| center | input | 1 | Alignment: 0 left-aligned, 1 center-aligned |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 duty, 1 period, 2 or 3 counter |
| wr_data | input | 8 | Write data |
| cnt_rd | output | 8 | Current count value |
| pwm_out | output | 1 | PWM output |

## Verification
The embedded assertions watch, on every cycle, that a frozen channel keeps its count, that a counter write lands at zero counting up, that the sawtooth wraps at period minus one and the triangle turns at the period, that the active registers stay put between period ends while enabled and follow the buffers while disabled, and that a zero or over-full setting pins the output. What the assertions cannot show is whether the whole waveform is right across many periods: the timing of buffered updates against the wrap, the output edges at the duty match under both polarities, and mode or polarity changes in mid-run. Those are shown by the bench, which runs directed corner cases and a long random sequence against its own cycle model of the count and output.

// File: rtl/pwm_pkg.sv
// Package: shared definitions for the buffered PWM channel.
// Assumes the write selector is two bits wide; both upper codes address the counter.
package pwm_pkg;

    typedef enum logic [1:0] {
        SEL_DUTY   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_CNT    = 2'd2,
        SEL_CNT_AL = 2'd3
    } wr_sel_e;

    // True when a selector value addresses the counter.
    function automatic logic sel_is_counter(input logic [1:0] sel);
        return sel[1];
    endfunction

endpackage

// File: rtl/pwm_regs.sv
// Module: pwm_regs
// Holds the duty and period buffers and their active copies.
// Assumes load_evt marks a period end or counter write in the same cycle;
// while the channel is disabled the active copies track the buffers every cycle.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chan_en,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         load_evt,
    output logic [W-1:0] duty_act,
    output logic [W-1:0] per_act
);

    logic [W-1:0] duty_buf, per_buf;
    logic [W-1:0] duty_buf_nxt, per_buf_nxt;
    logic         take;

    // Next buffer values, including a write arriving this cycle.
    always_comb begin
        duty_buf_nxt = duty_buf;
        per_buf_nxt  = per_buf;
        if (wr_en && wr_sel == SEL_DUTY)   duty_buf_nxt = wr_data;
        if (wr_en && wr_sel == SEL_PERIOD) per_buf_nxt  = wr_data;
    end

    assign take = load_evt || !chan_en;

    // Buffer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_buf <= '0;
            per_buf  <= '0;
        end else begin
            duty_buf <= duty_buf_nxt;
            per_buf  <= per_buf_nxt;
        end
    end

    // Active registers: refreshed on a load event or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
            per_act  <= '0;
        end else if (take) begin
            duty_act <= duty_buf_nxt;
            per_act  <= per_buf_nxt;
        end
    end

    p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !load_evt) |=> ($stable(duty_act) && $stable(per_act)))
        else $error("p_act_hold_r6");

    p_dis_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en) |=> (duty_act == duty_buf && per_act == per_buf))
        else $error("p_dis_follow_r7");

endmodule

// File: rtl/pwm_counter.sv
// Module: pwm_counter
// Up/down channel counter with sawtooth and triangle sequences.
// Assumes per_act is stable between period ends; a counter write wins over a tick.
// period_end pulses in the cycle whose edge returns the count to 0 at a boundary.
module pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chan_en,
    input  logic         tick,
    input  logic         center,
    input  logic         cnt_wr,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] cnt,
    output logic         period_end
);

    localparam logic [W:0] ONE_X = (W+1)'(1);

    logic         dir_up;
    logic [W-1:0] cnt_nxt;
    logic         dir_nxt;
    logic         step;
    logic         at_low;

    assign step   = chan_en && tick && !cnt_wr;
    assign at_low = (cnt <= W'(1));

    // Next count, direction and boundary flag.
    always_comb begin
        cnt_nxt    = cnt;
        dir_nxt    = dir_up;
        period_end = 1'b0;
        if (cnt_wr) begin
            cnt_nxt = '0;
            dir_nxt = 1'b1;
        end else if (step) begin
            if (!center) begin
                dir_nxt = 1'b1;
                if (per_act == '0 || ({1'b0, cnt} + ONE_X) >= {1'b0, per_act}) begin
                    cnt_nxt    = '0;
                    period_end = 1'b1;
                end else begin
                    cnt_nxt = cnt + W'(1);
                end
            end else if (per_act == '0) begin
                cnt_nxt    = '0;
                dir_nxt    = 1'b1;
                period_end = 1'b1;
            end else if (dir_up && cnt < per_act) begin
                cnt_nxt = cnt + W'(1);
            end else if (at_low) begin
                cnt_nxt    = '0;
                dir_nxt    = 1'b1;
                period_end = 1'b1;
            end else begin
                cnt_nxt = cnt - W'(1);
                dir_nxt = 1'b0;
            end
        end
    end

    // Count and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else begin
            cnt    <= cnt_nxt;
            dir_up <= dir_nxt;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !cnt_wr) |=> $stable(cnt))
        else $error("p_hold_r2");

    p_cwr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == '0 && dir_up))
        else $error("p_cwr_zero_r5");

    p_left_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !center && per_act != '0 && cnt == per_act - W'(1)) |=> (cnt == '0))
        else $error("p_left_wrap_r3");

    p_center_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && center && dir_up && per_act > W'(1) && cnt == per_act)
        |=> (!dir_up && cnt == $past(per_act) - W'(1)))
        else $error("p_center_peak_r4");

endmodule

// File: rtl/pwm_outgen.sv
// Module: pwm_outgen
// Decodes the output level from the count and the active settings.
// Assumes all inputs come from registers (or a static polarity pin), so the
// output has no path from the write port; clk/rst_n serve the checks only.
module pwm_outgen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] duty_act,
    input  logic [W-1:0] per_act,
    input  logic         pol,
    output logic         pwm_out
);

    logic active;

    // Active while below duty; zero period never active, full duty always active.
    always_comb begin
        if (per_act == '0)            active = 1'b0;
        else if (duty_act >= per_act) active = 1'b1;
        else                          active = (cnt < duty_act);
        pwm_out = pol ? active : !active;
    end

    p_zero_per_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_act == '0) |-> (pwm_out == !pol))
        else $error("p_zero_per_r9");

    p_full_duty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_act != '0 && duty_act >= per_act) |-> (pwm_out == pol))
        else $error("p_full_duty_r9");

endmodule

// File: rtl/pwm_chan8.sv
// Module: pwm_chan8
// One buffered PWM channel: register write port, counter, output decode.
// Assumes tick is a single-cycle clock-enable from an external prescaler.
module pwm_chan8
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chan_en,
    input  logic         tick,
    input  logic         pol,
    input  logic         center,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_rd,
    output logic         pwm_out
);

    logic         cnt_wr;
    logic         period_end;
    logic         load_evt;
    logic [W-1:0] duty_act, per_act, cnt;

    assign cnt_wr   = wr_en && sel_is_counter(wr_sel);
    assign load_evt = period_end || cnt_wr;
    assign cnt_rd   = cnt;

    pwm_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .load_evt (load_evt),
        .duty_act (duty_act),
        .per_act  (per_act)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .tick       (tick),
        .center     (center),
        .cnt_wr     (cnt_wr),
        .per_act    (per_act),
        .cnt        (cnt),
        .period_end (period_end)
    );

    pwm_outgen #(.W(W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .duty_act (duty_act),
        .per_act  (per_act),
        .pol      (pol),
        .pwm_out  (pwm_out)
    );

endmodule

// File: tb/tb_pwm_chan8.sv
// Bench for pwm_chan8: directed corners plus seeded random stimulus,
// checked every step against a cycle model built from the requirements.
module tb_pwm_chan8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0, tick = 1'b0, pol = 1'b1, center = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] cnt_rd;
    logic       pwm_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Model state.
    int m_cnt, m_dbuf, m_pbuf, m_dact, m_pact;
    bit m_up;

    always #5 clk = ~clk;

    pwm_chan8 dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tick(tick), .pol(pol),
        .center(center), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cnt_rd(cnt_rd), .pwm_out(pwm_out)
    );

    function automatic bit exp_out();
        bit act;
        if (m_pact == 0)           act = 0;
        else if (m_dact >= m_pact) act = 1;
        else                       act = (m_cnt < m_dact);
        return pol ? act : !act;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one clock edge using the driven inputs.
    task automatic model_edge();
        bit cw, bnd;
        int nd, np;
        cw  = wr_en && wr_sel[1];
        nd  = (wr_en && wr_sel == 2'd0) ? int'(wr_data) : m_dbuf;
        np  = (wr_en && wr_sel == 2'd1) ? int'(wr_data) : m_pbuf;
        bnd = 0;
        if (cw) begin
            m_cnt = 0; m_up = 1;
        end else if (chan_en && tick) begin
            if (!center) begin
                m_up = 1;
                if (m_pact == 0 || m_cnt + 1 >= m_pact) begin m_cnt = 0; bnd = 1; end
                else m_cnt++;
            end else if (m_pact == 0) begin
                m_cnt = 0; m_up = 1; bnd = 1;
            end else if (m_up && m_cnt < m_pact) begin
                m_cnt++;
            end else if (m_cnt <= 1) begin
                m_cnt = 0; m_up = 1; bnd = 1;
            end else begin
                m_cnt--; m_up = 0;
            end
        end
        if (cw || bnd || !chan_en) begin m_dact = nd; m_pact = np; end
        m_dbuf = nd; m_pbuf = np;
    endtask

    // One clock step: inputs already set; compare after the edge settles.
    task automatic step(input string ctag, input string otag);
        @(posedge clk);
        model_edge();
        #2;
        chk(ctag, int'(cnt_rd), m_cnt);
        chk(otag, int'(pwm_out), int'(exp_out()));
        wr_en = 0;
    endtask

    task automatic drive(input bit en, input bit tk, input bit we, input int sel, input int d);
        chan_en = en; tick = tk; wr_en = we; wr_sel = 2'(sel); wr_data = 8'(d);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cnt = 0; m_dbuf = 0; m_pbuf = 0; m_dact = 0; m_pact = 0; m_up = 1;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1;
        // R1: reset state
        chk("R1 cnt", int'(cnt_rd), 0);
        chk("R1 out", int'(pwm_out), 0);

        // R7: disabled buffer writes land at once
        drive(0, 1, 1, 1, 5); step("R7 cnt", "R7 out");
        drive(0, 1, 1, 0, 2); step("R7 cnt", "R7");
        chk("R7 active high", int'(pwm_out), 1);
        drive(0, 1, 1, 0, 0); step("R7 cnt", "R7");
        chk("R7 duty0 low", int'(pwm_out), 0);
        drive(0, 0, 1, 0, 2); step("R7 cnt", "R7");

        // R3/R8: left-aligned run, period 5 duty 2
        for (int i = 0; i < 12; i++) begin drive(1, 1, 0, 0, 0); step("R3", "R8"); end
        // R6: duty buffer written mid-period is held until the wrap
        drive(1, 0, 1, 0, 4); step("R6 cnt", "R6 out");
        for (int i = 0; i < 8; i++) begin drive(1, 1, 0, 0, 0); step("R3", "R6"); end

        // R2: disabled with ticks holds the count, resumes from it
        drive(0, 1, 0, 0, 0); step("R2 hold", "R8");
        drive(0, 1, 0, 0, 0); step("R2 hold", "R8");
        drive(1, 0, 0, 0, 0); step("R2 no tick", "R8");
        drive(1, 1, 0, 0, 0); step("R2 resume", "R8");

        // R5: counter write with tick loads buffers at once
        drive(1, 1, 1, 1, 7); step("R5", "R8");
        drive(1, 1, 1, 0, 3); step("R5", "R8");
        drive(1, 1, 1, 3, 8'hA5); step("R5 cnt", "R5 out");
        chk("R5 zero", int'(cnt_rd), 0);
        chk("R5 polarity level", int'(pwm_out), 1);
        for (int i = 0; i < 9; i++) begin drive(1, 1, 0, 0, 0); step("R3", "R8"); end

        // R4: center-aligned, period 3 then period 1
        center = 1;
        drive(1, 1, 1, 1, 3); step("R4", "R8");
        drive(1, 1, 1, 0, 2); step("R4", "R8");
        drive(1, 1, 1, 2, 0); step("R4", "R8");
        for (int i = 0; i < 14; i++) begin drive(1, 1, 0, 0, 0); step("R4", "R8"); end
        drive(1, 1, 1, 1, 1); step("R4", "R8");
        drive(1, 1, 1, 2, 0); step("R4", "R8");
        for (int i = 0; i < 6; i++) begin drive(1, 1, 0, 0, 0); step("R4 p1", "R8"); end

        // R8: inverted polarity in center mode
        pol = 0;
        drive(1, 1, 1, 1, 6); step("R4", "R8");
        drive(1, 1, 1, 0, 3); step("R4", "R8");
        drive(1, 1, 1, 2, 0); step("R4", "R8 pol0");
        for (int i = 0; i < 14; i++) begin drive(1, 1, 0, 0, 0); step("R4", "R8 pol0"); end

        // R9: zero period and over-full duty
        pol = 1; center = 0;
        drive(1, 1, 1, 1, 0); step("R9", "R9");
        drive(1, 1, 1, 2, 0); step("R9", "R9");
        for (int i = 0; i < 4; i++) begin drive(1, 1, 0, 0, 0); step("R9 cnt0", "R9 zero per"); end
        drive(1, 1, 1, 1, 4); step("R9", "R9");
        drive(1, 1, 1, 0, 9); step("R9", "R9");
        drive(1, 1, 1, 2, 0); step("R9", "R9");
        for (int i = 0; i < 8; i++) begin drive(1, 1, 0, 0, 0); step("R3", "R9 full duty"); end

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            bit en, tk, we;
            int sel, d;
            if ($urandom % 200 == 0) pol = ~pol;
            if ($urandom % 150 == 0) center = ~center;
            en  = ($urandom % 16) != 0;
            tk  = ($urandom % 2) != 0;
            we  = ($urandom % 10) == 0;
            sel = int'($urandom % 4);
            d   = ($urandom % 8 == 0) ? int'($urandom % 256) : int'($urandom % 12);
            drive(en, tk, we, sel, d);
            step(center ? "R4 rand" : "R3 rand", "R8 rand");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule